// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the host-side front end for PCI configuration accesses coming from a big-endian CPU bus. The CPU reaches two 4 KiB windows through one request strobe. The address window holds a 32-bit configuration address register. The data window starts a configuration cycle. On each data-window access, the block rewrites the stored address into a standard bus/device/function/register configuration address. It then issues exactly one read or write on a simple request/response port and returns the result to the CPU.

The stored address can use one of three encodings. In the pass-through form, bit 31 is set. In the type-1 style form, bit 31 is clear and bit 0 is set. In the one-hot IDSEL form, both bits are clear and the device slot is given by a single set bit in the upper field. The one-hot form is turned into a binary slot number by searching for the lowest set bit. Data crossing the data window is byte-swapped according to the access length, so that the little-endian configuration space reads correctly from the big-endian CPU.

Top module: `pci_cfg_xlate`

## Requirements
- R1: A synchronous reset clears the configuration address register to zero. A read of the address window (`cpu_sel`=0) after reset returns 0.
- R2: An address-window access (`cpu_sel`=0) completes without any bus cycle. A write stores `cpu_wdata` unswapped. A read returns the stored value unswapped. The offset and length are ignored.
- R3: If stored bit 31 is 1, the outgoing address is the stored value with bits 1..0 replaced by offset bits 1..0.
- R4: If stored bit 31 is 0 and bit 0 is 1, the outgoing address is the stored value with bits 2..0 replaced by offset bits 2..0.
- R5: If stored bits 31 and 0 are both 0, the outgoing address is built as follows:
  - bits 15..11 hold the slot, which is the index of the lowest set stored bit in 31..11, minus 11;
  - bits 10..8 hold the function, taken from stored bits 10..8;
  - bits 7..3 hold stored bits 7..3;
  - bits 2..0 hold offset bits 2..0;
  - bits 31..16 are zero.
- R6: In the one-hot form with no stored bit set in 31..11, no bus cycle is issued. A read returns 32'hFFFF_FFFF, and a write is dropped.
- R7: Write data goes to the bus swapped by `cpu_len`:
  - length 1 forwards byte 0 unchanged, with the upper bytes zero;
  - length 2 exchanges bytes 0 and 1, with the upper bytes zero;
  - length 4 (and any other code) reverses all four bytes.
- R8: Read data from the bus is swapped by the same rule as R7, using the access's length, before it appears on `cpu_rdata`.
- R9: At most one configuration request is outstanding at a time.
  - `bus_req_valid` stays high, with address, write flag and data stable, until `bus_rsp_valid` is seen.
  - `cpu_ready` pulses for one cycle, one clock after the response.
  - A `cpu_valid` strobe that arrives while a request is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | One-cycle request strobe, accepted only when idle |
| cpu_sel | input | 1 | 0 = address window, 1 = data window |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_off | input | 12 | Byte offset inside the 4 KiB window |
| cpu_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with `cpu_ready` |
| bus_req_valid | output | 1 | Configuration request pending |
| bus_req_we | output | 1 | Request is a write |
| bus_req_addr | output | 32 | Translated configuration address |
| bus_req_len | output | 3 | Access length of the request |
| bus_req_wdata | output | 32 | Swapped write data |
| bus_rsp_valid | input | 1 | Downstream completion |
| bus_rsp_rdata | input | 32 | Downstream read data |

## Verification
The hardest state to reach from the ports is a second CPU strobe landing while a configuration request is still in flight. The downstream model in the bench holds each response back for a varying number of cycles. While it waits, the driver fires an address-window write into that gap. A later read of the address register then shows whether the stray strobe leaked in. The one-hot corner cases are covered by separate accesses:
- an empty IDSEL field;
- the lowest and highest slot bits;
- two set bits at once, where the lowest one must win.

// File: rtl/pci_cfg_xlate_pkg.sv
package pci_cfg_xlate_pkg;

    localparam int DATA_W    = 32;
    localparam int OFF_W     = 12;
    localparam int LEN_W     = 3;
    localparam int SLOT_LO   = 11;
    localparam int SLOT_HI   = 31;
    localparam int SLOT_W    = 5;

    typedef enum logic [1:0] {
        FMT_PASS   = 2'd0,
        FMT_TYPE1  = 2'd1,
        FMT_ONEHOT = 2'd2
    } cfg_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        cfg_fmt_e          fmt;
        logic [DATA_W-1:0] addr;
    } xlate_t;

endpackage

// File: rtl/pci_cfg_lane_swap.sv
module pci_cfg_lane_swap
    import pci_cfg_xlate_pkg::*;
#(
    parameter int BYTES = DATA_W / 8
) (
    input  logic [BYTES*8-1:0] din,
    input  logic [LEN_W-1:0]   len,
    output logic [BYTES*8-1:0] dout
);
    logic [BYTES*8-1:0] rev_full;

    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_rev
            assign rev_full[g*8 +: 8] = din[(BYTES-1-g)*8 +: 8];
        end
    endgenerate

    always_comb begin
        dout = '0;
        unique case (len)
            3'd1: dout[7:0] = din[7:0];
            3'd2: begin
                dout[7:0]  = din[15:8];
                dout[15:8] = din[7:0];
            end
            default: dout = rev_full;
        endcase
    end
endmodule

// File: rtl/pci_cfg_addr_decode.sv
module pci_cfg_addr_decode
    import pci_cfg_xlate_pkg::*;
(
    input  logic [DATA_W-1:0] stored,
    input  logic [OFF_W-1:0]  off,
    output xlate_t            xl
);
    logic [SLOT_W-1:0] slot;
    logic              found;

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = SLOT_HI; i >= SLOT_LO; i--) begin
            if (stored[i]) begin
                slot  = SLOT_W'(i - SLOT_LO);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        xl = '0;
        if (stored[DATA_W-1]) begin
            xl.fmt  = FMT_PASS;
            xl.hit  = 1'b1;
            xl.addr = {stored[DATA_W-1:2], off[1:0]};
        end else if (stored[0]) begin
            xl.fmt  = FMT_TYPE1;
            xl.hit  = 1'b1;
            xl.addr = {stored[DATA_W-1:3], off[2:0]};
        end else begin
            xl.fmt  = FMT_ONEHOT;
            xl.hit  = found;
            xl.addr = {16'h0000, slot, stored[10:8], stored[7:3], off[2:0]};
        end
    end
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
    import pci_cfg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [LEN_W-1:0]  cpu_len,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] wdata_sw,
    input  xlate_t            xl,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] rsp_sw,
    output logic [DATA_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_we,
    output logic [DATA_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata
);
    seq_state_e        state;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            addr_q        <= '0;
            len_q         <= '0;
            rdata_q       <= '0;
            bus_req_valid <= 1'b0;
            bus_req_we    <= 1'b0;
            bus_req_addr  <= '0;
            bus_req_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cpu_valid) begin
                    len_q <= cpu_len;
                    if (!cpu_sel) begin
                        rdata_q <= addr_q;
                        if (cpu_we) addr_q <= cpu_wdata;
                        state <= ST_DONE;
                    end else if (xl.hit) begin
                        bus_req_valid <= 1'b1;
                        bus_req_we    <= cpu_we;
                        bus_req_addr  <= xl.addr;
                        bus_req_wdata <= wdata_sw;
                        state         <= ST_BUS;
                    end else begin
                        rdata_q <= '1;
                        state   <= ST_DONE;
                    end
                end
                ST_BUS: if (bus_rsp_valid) begin
                    bus_req_valid <= 1'b0;
                    rdata_q       <= rsp_sw;
                    state         <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state == ST_DONE);
    assign cpu_rdata = rdata_q;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (addr_q == '0));

    a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_rsp_valid) |=>
            (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata)
             && $stable(bus_req_we)));

    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    a_r9_ready_after_bus: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req_valid);

    a_r6_empty_no_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cpu_valid && cpu_sel && !xl.hit) |=> !bus_req_valid);
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
    import pci_cfg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_valid,
    input  logic        cpu_sel,
    input  logic        cpu_we,
    input  logic [11:0] cpu_off,
    input  logic [2:0]  cpu_len,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [31:0] cpu_rdata,
    output logic        bus_req_valid,
    output logic        bus_req_we,
    output logic [31:0] bus_req_addr,
    output logic [2:0]  bus_req_len,
    output logic [31:0] bus_req_wdata,
    input  logic        bus_rsp_valid,
    input  logic [31:0] bus_rsp_rdata
);
    logic [DATA_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rsp_sw;
    xlate_t            xl;

    pci_cfg_addr_decode u_decode (
        .stored (addr_q),
        .off    (cpu_off),
        .xl     (xl)
    );

    pci_cfg_lane_swap u_swap_wr (
        .din  (cpu_wdata),
        .len  (cpu_len),
        .dout (wdata_sw)
    );

    pci_cfg_lane_swap u_swap_rd (
        .din  (bus_rsp_rdata),
        .len  (len_q),
        .dout (rsp_sw)
    );

    pci_cfg_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_valid),
        .cpu_sel       (cpu_sel),
        .cpu_we        (cpu_we),
        .cpu_len       (cpu_len),
        .cpu_wdata     (cpu_wdata),
        .wdata_sw      (wdata_sw),
        .xl            (xl),
        .bus_rsp_valid (bus_rsp_valid),
        .rsp_sw        (rsp_sw),
        .addr_q        (addr_q),
        .len_q         (len_q),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .bus_req_valid (bus_req_valid),
        .bus_req_we    (bus_req_we),
        .bus_req_addr  (bus_req_addr),
        .bus_req_wdata (bus_req_wdata)
    );

    assign bus_req_len = len_q;
endmodule

// File: tb/pci_cfg_xlate_tb.sv
module pci_cfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_off = '0;
    logic [2:0]  cpu_len = 3'd4;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bus_req_valid, bus_req_we;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic [2:0]  bus_req_len;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [2:0]  len;
        logic [31:0] wdata;
        logic [31:0] rsp;
        string       tag;
    } bus_item_t;

    typedef struct {
        bit          chk;
        logic [31:0] rdata;
        string       tag;
    } cpu_item_t;

    bus_item_t bus_q[$];
    cpu_item_t cpu_q[$];

    always #2.5 clk = ~clk;

    pci_cfg_xlate u_dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_sel(cpu_sel),
        .cpu_we(cpu_we), .cpu_off(cpu_off), .cpu_len(cpu_len),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_we(bus_req_we),
        .bus_req_addr(bus_req_addr), .bus_req_len(bus_req_len),
        .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] swp(input logic [31:0] d, input logic [2:0] l);
        if (l == 3'd1) return {24'h0, d[7:0]};
        if (l == 3'd2) return {16'h0, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // driver: pushes expectations, strobes the request, waits for completion
    task automatic access(input bit sel, input bit we, input logic [11:0] off,
                          input logic [2:0] len, input logic [31:0] wd,
                          input bit exp_bus, input logic [31:0] exp_addr,
                          input logic [31:0] rsp, input bit chk_rd,
                          input logic [31:0] exp_rd, input string tag,
                          input bit poke_busy);
        bus_item_t b;
        cpu_item_t c;
        if (exp_bus) begin
            b.addr = exp_addr; b.we = we; b.len = len;
            b.wdata = swp(wd, len); b.rsp = rsp; b.tag = tag;
            bus_q.push_back(b);
        end
        c.chk = chk_rd; c.rdata = exp_rd; c.tag = tag;
        cpu_q.push_back(c);
        cpu_sel = sel; cpu_we = we; cpu_off = off; cpu_len = len; cpu_wdata = wd;
        cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        if (poke_busy) begin
            cpu_sel = 1'b0; cpu_we = 1'b1; cpu_wdata = 32'hDEAD_BEEF;
            cpu_valid = 1'b1;
            @(negedge clk);
            cpu_valid = 1'b0;
        end
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // downstream responder / bus monitor
    int lat_sel = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req_valid) begin
                if (bus_q.size() == 0) begin
                    check(0, "R6 unexpected bus cycle", bus_req_addr, 32'h0);
                    bus_rsp_valid = 1'b1;
                    @(negedge clk);
                    bus_rsp_valid = 1'b0;
                end else begin
                    bus_item_t b;
                    int lat;
                    b = bus_q.pop_front();
                    check(bus_req_addr == b.addr, {b.tag, " addr"}, bus_req_addr, b.addr);
                    check(bus_req_we == b.we, {b.tag, " we"}, 32'(bus_req_we), 32'(b.we));
                    check(bus_req_len == b.len, {b.tag, " len"}, 32'(bus_req_len), 32'(b.len));
                    if (b.we)
                        check(bus_req_wdata == b.wdata, {b.tag, " R7 wdata"}, bus_req_wdata, b.wdata);
                    lat = (lat_sel % 3 == 0) ? 2 : (lat_sel % 3 == 1) ? 3 : 5;
                    lat_sel++;
                    for (int k = 0; k < lat; k++) begin
                        @(negedge clk);
                        check(bus_req_valid && bus_req_addr == b.addr,
                              "R9 request held", bus_req_addr, b.addr);
                        check(!cpu_ready, "R9 no early ready", 32'(cpu_ready), 32'h0);
                    end
                    bus_rsp_rdata = b.rsp;
                    bus_rsp_valid = 1'b1;
                    @(negedge clk);
                    bus_rsp_valid = 1'b0;
                    check(cpu_ready, "R9 ready one cycle after response", 32'(cpu_ready), 32'h1);
                end
            end
        end
    end

    // CPU-side monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && cpu_ready) begin
            if (cpu_q.size() == 0) begin
                check(0, "R9 spurious ready", 32'h1, 32'h0);
            end else begin
                cpu_item_t c;
                c = cpu_q.pop_front();
                if (c.chk) check(cpu_rdata == c.rdata, c.tag, cpu_rdata, c.rdata);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog expired", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !bus_req_valid, "R1 idle outputs after reset",
              {30'h0, cpu_ready, bus_req_valid}, 32'h0);
        // R1: reset value of the address register
        access(0, 0, 12'h000, 3'd4, 0, 0, 0, 0, 1, 32'h0, "R1 reset address", 0);
        // R2: address register write/read, offset ignored, no swap
        access(0, 1, 12'h7F4, 3'd2, 32'hCAFE_F00D, 0, 0, 0, 0, 0, "R2 write", 0);
        access(0, 0, 12'h123, 3'd1, 0, 0, 0, 0, 1, 32'hCAFE_F00D, "R2 readback", 0);
        // R3 pass-through form, R8 4-byte read swap, R9 busy strobe ignored
        access(0, 1, 0, 3'd4, 32'h8000_1A7C, 0, 0, 0, 0, 0, "R3 set", 0);
        access(1, 0, 12'h00E, 3'd4, 0, 1, 32'h8000_1A7E, 32'h1122_3344, 1,
               32'h4433_2211, "R3 R8 read len4", 1);
        access(0, 0, 0, 3'd4, 0, 0, 0, 0, 1, 32'h8000_1A7C, "R9 busy strobe ignored", 0);
        // R3 with 1-byte write, R7
        access(0, 1, 0, 3'd4, 32'h8000_0000, 0, 0, 0, 0, 0, "R3 set2", 0);
        access(1, 1, 12'hFF1, 3'd1, 32'h1234_565A, 1, 32'h8000_0001, 0, 0, 0,
               "R3 R7 write len1", 0);
        // R4 type-1 style, R7 2-byte write
        access(0, 1, 0, 3'd4, 32'h0012_3455, 0, 0, 0, 0, 0, "R4 set", 0);
        access(1, 1, 12'h003, 3'd2, 32'h0000_ABCD, 1, 32'h0012_3453, 0, 0, 0,
               "R4 R7 write len2", 0);
        // R5 one-hot: bits 20 and 14 set -> slot 3, func 5, reg A0, R8 len1
        access(0, 1, 0, 3'd4, 32'h0010_45A4, 0, 0, 0, 0, 0, "R5 set", 0);
        access(1, 0, 12'hFF7, 3'd1, 0, 1, 32'h0000_1DA7, 32'hAABB_CCC3, 1,
               32'h0000_00C3, "R5 R8 read len1 lowest bit", 0);
        // R5 top slot bit 30 -> slot 19, R7 len4
        access(0, 1, 0, 3'd4, 32'h4000_0008, 0, 0, 0, 0, 0, "R5 set2", 0);
        access(1, 1, 12'h000, 3'd4, 32'h0102_0304, 1, 32'h0000_9808, 0, 0, 0,
               "R5 R7 write slot19", 0);
        // R5 bottom slot bit 11 -> slot 0, R8 len2
        access(0, 1, 0, 3'd4, 32'h0000_0B10, 0, 0, 0, 0, 0, "R5 set3", 0);
        access(1, 0, 12'h001, 3'd2, 0, 1, 32'h0000_0311, 32'h1234_BEEF, 1,
               32'h0000_EFBE, "R5 R8 read len2 slot0", 0);
        // R6 empty one-hot field
        access(0, 1, 0, 3'd4, 32'h0000_07F0, 0, 0, 0, 0, 0, "R6 set", 0);
        access(1, 0, 12'h004, 3'd4, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R6 empty read", 0);
        access(1, 1, 12'h004, 3'd4, 32'h5555_AAAA, 0, 0, 0, 0, 0, "R6 empty write", 0);
        access(0, 0, 0, 3'd4, 0, 0, 0, 0, 1, 32'h0000_07F0, "R6 register intact", 0);
        repeat (4) @(negedge clk);
        check(bus_q.size() == 0 && cpu_q.size() == 0, "R9 scoreboard drained",
              32'(bus_q.size() + cpu_q.size()), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule